// File: doc/BRIEF.md
# Cancellable Register-Stage Pipeline

This block is a chain of register stages that moves a payload word from an upstream valid/ready port to a downstream port. The downstream port has a third control next to valid and ready: cancel. Cancel removes the transaction that the last stage currently presents. Between stages, a small test datapath adds a fixed step to the word, so each result shows that it went through every stage exactly once.

The upstream side follows normal stream rules. A word is taken on a clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high when the first stage is empty or when that stage's contents are leaving on the same edge, so gaps in the chain fill up. The downstream side sees a word leave the last stage in one of two ways. It is delivered when `out_ready` is high and `out_cancel` is low. It is discarded when `out_cancel` is high, whatever the value of `out_ready`. While `out_valid` is low, `out_ready` and `out_cancel` have no effect.

Three status pins decode the output node for commit logic and reset logic:
- `out_fire` means the word is being delivered.
- `out_move` means the word will be gone from the node after the edge.
- `out_canceling` means the word is being dropped.

Top module: `cxp_chain`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1 while the downstream controls are low. Only the valid flags are reset.
- R2: A word accepted into an empty chain with `out_ready` held high shows up on `out_valid` exactly STAGES clock edges after the edge that accepted it.
- R3: Every delivered word equals the accepted word plus STAGES*STEP, modulo 2^WIDTH. Delivered words come out in the order they were accepted.
- R4: While `out_valid`=1, `out_ready`=0 and `out_cancel`=0 (the blocked case), `out_valid` stays 1 and `out_data` keeps its value across the edge. Once raised, `out_valid` falls only after an edge on which ready or cancel was high.
- R5: `out_fire` = valid AND ready AND NOT cancel. `out_move` = valid AND (ready OR cancel). `out_canceling` = valid AND cancel.
- R6: A word that is presented while `out_cancel` is high is never delivered later. The number of accepted words equals the number of delivered words plus the number of canceled words.
- R7: When every stage holds a word and the output is blocked, `in_ready` is 0. A chain blocked from empty therefore accepts exactly STAGES words.
- R8: Canceling the output word clears `out_valid` on the next edge if no word moves into the last stage on that edge. If one does move in, `out_valid` stays 1 and the next word is presented.
- R9: With `in_valid` and `out_ready` held high, the chain takes one word on every cycle. Over N cycles starting from empty, N-STAGES words are delivered.
- R10: While `out_valid` is 0, `out_ready` and `out_cancel` have no effect. A word pushed afterwards is delivered intact and is not counted as canceled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the valid flags |
| in_valid | input | 1 | Upstream word present |
| in_ready | output | 1 | Chain can take the upstream word on this edge |
| in_data | input | WIDTH | Upstream payload word |
| out_valid | output | 1 | Last stage holds a word |
| out_ready | input | 1 | Downstream accepts the word |
| out_cancel | input | 1 | Downstream drops the word |
| out_data | output | WIDTH | Payload of the last stage |
| out_fire | output | 1 | Word is delivered on this edge |
| out_move | output | 1 | Word leaves the output node on this edge |
| out_canceling | output | 1 | Word is discarded on this edge |

## Verification
The bench targets four corner cases:
- Cancel with ready also high. A design that treated this case as delivery would hand on a dropped word, and the scoreboard would see that word's successor arrive one slot late.
- Cancel on a full chain compared with cancel on a single word. A design that always cleared valid on cancel would lose the word moving in behind it. A design that never cleared valid would present the dropped word again.
- A blocked full chain. Here a ready that ignores the held word lets in one word too many, or overwrites a word.
- Cancel and ready pulsed on an empty chain. A design that acted on them while empty would corrupt the next word or count a phantom cancel.

// File: rtl/cxp_pkg.sv
package cxp_pkg;

  // Decoded status of one node in the chain.
  typedef struct packed {
    logic fire;
    logic move;
    logic kill;
  } cxp_stat_t;

  // Status of a node from its valid, ready and cancel controls.
  function automatic cxp_stat_t cxp_eval(input logic v, input logic r, input logic c);
    cxp_stat_t s;
    s.fire = v & r & ~c;
    s.move = v & (r | c);
    s.kill = v & c;
    return s;
  endfunction

endpackage

// File: rtl/cxp_step.sv
module cxp_step #(
  parameter int unsigned        WIDTH = 16,
  parameter logic [WIDTH-1:0]   STEP  = '0
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] y_o
);
  // Test datapath between stages: add a fixed step, wrapping at 2^WIDTH.
  always_comb y_o = a_i + STEP;
endmodule

// File: rtl/cxp_node_status.sv
module cxp_node_status
  import cxp_pkg::*;
(
  input  logic v_i,
  input  logic r_i,
  input  logic c_i,
  output logic fire_o,
  output logic move_o,
  output logic kill_o
);
  cxp_stat_t st;
  always_comb begin
    st     = cxp_eval(v_i, r_i, c_i);
    fire_o = st.fire;
    move_o = st.move;
    kill_o = st.kill;
  end
endmodule

// File: rtl/cxp_stage.sv
module cxp_stage #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [WIDTH-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  input  logic             dn_cancel,
  output logic [WIDTH-1:0] dn_data
);
  logic             vld_q;
  logic [WIDTH-1:0] dat_q;

  // Take a new word when the slot is empty or its word leaves this edge.
  assign up_ready = ~vld_q | dn_ready | dn_cancel;

  always_ff @(posedge clk) begin
    if (rst)           vld_q <= 1'b0;
    else if (up_ready) vld_q <= up_valid;
  end

  // The payload register has no reset.
  always_ff @(posedge clk) begin
    if (up_ready) dat_q <= up_data;
  end

  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    up_valid && up_ready |=> dn_valid)
    else $error("stage lost an accepted word");

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready && !dn_cancel |=> dn_valid && $stable(dn_data))
    else $error("blocked word changed");

  assert_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(dn_valid) |-> $past(dn_ready || dn_cancel))
    else $error("valid fell without a move");

  assert_drop_R8: assert property (@(posedge clk) disable iff (rst)
    dn_valid && dn_cancel && !up_valid |=> !dn_valid)
    else $error("canceled word still presented");
endmodule

// File: rtl/cxp_chain.sv
module cxp_chain #(
  parameter int unsigned      WIDTH  = 16,
  parameter int unsigned      STAGES = 3,
  parameter logic [WIDTH-1:0] STEP   = 16'h0011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  input  logic             out_cancel,
  output logic [WIDTH-1:0] out_data,
  output logic             out_fire,
  output logic             out_move,
  output logic             out_canceling
);
  localparam int unsigned LAST = STAGES;

  logic             nv [0:LAST];
  logic             nr [0:LAST];
  logic             nc [1:LAST];
  logic [WIDTH-1:0] nd [0:LAST];
  logic [WIDTH-1:0] sd [0:LAST-1];

  assign nv[0]     = in_valid;
  assign in_ready  = nr[0];
  assign nd[0]     = in_data;
  assign nr[LAST]  = out_ready;
  assign nc[LAST]  = out_cancel;
  assign out_valid = nv[LAST];
  assign out_data  = nd[LAST];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cxp_step #(.WIDTH(WIDTH), .STEP(STEP)) u_step (
      .a_i(nd[k]),
      .y_o(sd[k])
    );
    // Only the output node can be canceled; inner links never drop words.
    if (k + 1 < STAGES) begin : g_inner
      assign nc[k+1] = 1'b0;
    end
    cxp_stage #(.WIDTH(WIDTH)) u_reg (
      .clk      (clk),
      .rst      (rst),
      .up_valid (nv[k]),
      .up_ready (nr[k]),
      .up_data  (sd[k]),
      .dn_valid (nv[k+1]),
      .dn_ready (nr[k+1]),
      .dn_cancel(nc[k+1]),
      .dn_data  (nd[k+1])
    );
  end

  cxp_node_status u_stat (
    .v_i   (out_valid),
    .r_i   (out_ready),
    .c_i   (out_cancel),
    .fire_o(out_fire),
    .move_o(out_move),
    .kill_o(out_canceling)
  );
endmodule

// File: tb/tb_cxp_chain.sv
module tb_cxp_chain;
  localparam int unsigned W = 16;
  localparam int unsigned NST = 3;
  localparam logic [15:0] STEP = 16'h0011;
  localparam logic [15:0] OFF = 16'(NST * STEP);
  localparam int CLK_PERIOD = 10;
  // Table columns: {in_valid, out_ready, out_cancel}
  localparam logic [2:0] PAT [16] = '{3'b110, 3'b110, 3'b100, 3'b111, 3'b010, 3'b110, 3'b101, 3'b110,
                                      3'b000, 3'b110, 3'b011, 3'b110, 3'b100, 3'b010, 3'b111, 3'b110};

  logic clk = 0, rst = 1;
  logic in_valid = 0, out_ready = 0, out_cancel = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, out_fire, out_move, out_canceling;
  logic [W-1:0] out_data;

  int n_chk = 0, n_fail = 0, n_acc = 0, n_del = 0, n_cxl = 0, seq = 0;
  logic [W-1:0] q[$];
  bit done = 0;

  cxp_chain #(.WIDTH(W), .STAGES(NST), .STEP(STEP)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, score before the edge, idle after it.
  task automatic step(input logic iv, input logic ordy, input logic ocan);
    logic [W-1:0] e;
    @(negedge clk);
    in_valid = iv; out_ready = ordy; out_cancel = ocan;
    in_data = 16'(seq * 16'h1357 + 16'h0042);
    #1;
    chk(out_fire == (out_valid && ordy && !ocan), "R5 fire", 32'(out_fire), 32'(out_valid && ordy && !ocan));
    chk(out_move == (out_valid && (ordy || ocan)), "R5 move", 32'(out_move), 32'(out_valid && (ordy || ocan)));
    chk(out_canceling == (out_valid && ocan), "R5 canceling", 32'(out_canceling), 32'(out_valid && ocan));
    if (out_valid && (ocan || ordy)) begin
      if (q.size() == 0) chk(0, "R6 word from nowhere", 32'(out_data), 0);
      else begin
        e = q.pop_front();
        if (ocan) n_cxl++;
        else begin
          n_del++;
          chk(out_data == 16'(e + OFF), "R3 data/order", 32'(out_data), 32'(16'(e + OFF)));
        end
      end
    end
    if (iv && in_ready) begin q.push_back(in_data); seq++; n_acc++; end
    @(posedge clk); #1;
    in_valid = 0; out_ready = 0; out_cancel = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && q.size() != 0; i++) step(0, 1, 0);
    chk(q.size() == 0 && !out_valid, "R6 drain empty", 32'(q.size()), 0);
  endtask

  initial begin
    int a0, d0, c0;
    logic [W-1:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk(!out_valid, "R1 valid after reset", 32'(out_valid), 0);
    chk(in_ready, "R1 ready after reset", 32'(in_ready), 1);

    // R10: ready/cancel on an empty chain do nothing
    c0 = n_cxl; d0 = n_del;
    step(0, 1, 1); step(0, 0, 1); step(0, 1, 0);
    chk(!out_valid, "R10 still empty", 32'(out_valid), 0);
    step(1, 0, 1);
    drain();
    chk(n_cxl == c0 && n_del == d0 + 1, "R10 word intact", 32'(n_del - d0), 1);

    // R2: latency
    step(1, 1, 0);
    chk(out_valid == (NST == 1), "R2 latency 1", 32'(out_valid), 32'(NST == 1));
    for (int i = 2; i <= NST; i++) begin
      step(0, 1, 0);
      chk(out_valid == (i == NST), "R2 latency", 32'(out_valid), 32'(i == NST));
    end
    drain();

    // R7/R4: block a full chain
    a0 = n_acc;
    for (int i = 0; i < NST + 3; i++) step(1, 0, 0);
    chk(n_acc - a0 == NST, "R7 words taken when blocked", 32'(n_acc - a0), NST);
    #1;
    chk(!in_ready, "R7 in_ready low when full", 32'(in_ready), 0);
    held = out_data;
    step(1, 0, 0);
    chk(out_valid && out_data == held, "R4 blocked hold", 32'(out_data), 32'(held));
    // R8 with a word moving in
    step(0, 0, 1);
    chk(out_valid, "R8 refill valid", 32'(out_valid), 1);
    chk(out_data == 16'(q[0] + OFF), "R8 refill data", 32'(out_data), 32'(16'(q[0] + OFF)));
    drain();
    // R8 clear: single word
    step(1, 0, 0);
    for (int i = 1; i < NST; i++) step(0, 0, 0);
    chk(out_valid, "R8 single word presented", 32'(out_valid), 1);
    c0 = n_cxl;
    step(0, 0, 1);
    chk(!out_valid, "R8 cleared after cancel", 32'(out_valid), 0);
    chk(n_cxl == c0 + 1, "R6 cancel counted", 32'(n_cxl - c0), 1);
    drain();

    // R9: throughput
    a0 = n_acc; d0 = n_del;
    for (int i = 0; i < 12; i++) step(1, 1, 0);
    chk(n_acc - a0 == 12, "R9 accepts per cycle", 32'(n_acc - a0), 12);
    chk(n_del - d0 == 12 - NST, "R9 deliveries", 32'(n_del - d0), 32'(12 - NST));
    drain();

    // Table walk: mixed backpressure and cancels
    for (int p = 0; p < 12; p++)
      for (int i = 0; i < 16; i++) begin
        logic [2:0] v;
        v = PAT[(i + p * 5) % 16];
        step(v[2], v[1], v[0]);
      end
    drain();
    chk(n_acc == n_del + n_cxl, "R6 accepted = delivered + canceled", 32'(n_acc), 32'(n_del + n_cxl));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule